// File: doc/BRIEF.md
# Scan Access Tester Authentication Controller

This block sits in front of a scan chain and keeps it closed until an external tester proves it holds a secret key. When the tester raises its link request, the controller starts a clock toward the tester. On that clock it pulls in a serial key one bit at a time. Once the whole key has arrived, the controller compares it with a key fixed inside the block. A match opens scan access. A mismatch is reported to the tester as a failure.

Failed attempts are counted for the life of the power-on period. When the failure limit is reached, the controller locks. While locked it answers no further requests. Only a power-on reset clears the lock. The internal key, the key length and the failure limit are parameters.

Top module: `scan_auth_gate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `tck_o`, `fail_o`, `locked_o` and `scan_en_o` are all 0.
- R2: After `req_i` is seen high, `tck_o` toggles every clock cycle, starting low. Each 2-cycle tester-clock period captures one key bit from `key_bit_i`: the bit is sampled at the clock edge that ends the high phase of `tck_o`. Bits arrive most significant first, and `KEY_W` bits (default 32) make up one key.
- R3: A key is evaluated only after all `KEY_W` bits have been captured. If `req_i` falls before that, the partial key is discarded and no grant or failure results. The next request starts again from the first bit.
- R4: If the captured key equals `KEY`, `scan_en_o` goes high 2 clock cycles after the capture of the last bit. It then stays high until `end_test_i` is seen high, or until reset.
- R5: If the captured key differs from `KEY`, `fail_o` is high for exactly one cycle, 2 cycles after the capture of the last bit. The failed-attempt count rises by one, and a new request restarts key capture from the first bit.
- R6: When the failure that brings the count to `MAX_TRIES` (default 4) occurs, `locked_o` rises in the same cycle as that failure's `fail_o` pulse. `locked_o` then stays high until reset. The failure count is not cleared by a successful authentication.
- R7: While `locked_o` is high, requests are ignored: `tck_o` stays 0, `scan_en_o` stays 0 even when the correct key is presented, and `fail_o` stays 0.
- R8: `tck_o` is 0 whenever no key capture is in progress, including the whole time `scan_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| req_i | input | 1 | Tester link request |
| key_bit_i | input | 1 | Serial key data from tester |
| end_test_i | input | 1 | Ends an authenticated scan session |
| tck_o | output | 1 | Clock driven toward the tester for key transfer |
| fail_o | output | 1 | One-cycle pulse per failed attempt |
| locked_o | output | 1 | High once the failure limit is reached |
| scan_en_o | output | 1 | Scan access grant |

## Verification
The bench checks the following corner cases:
- A key with only its last bit wrong and a key with only its first bit wrong. A design that compares too few bits, or shifts in the wrong order, would grant access on one of them.
- A request dropped after 31 of 32 bits. A design that evaluates partial keys would report a failure here, and one that fails to restart from the first bit would reject the following correct key.
- The fourth failure. It must raise the lock in the same cycle as its pulse, not one failure early or late.
- A correct key sent while locked, which must produce no tester clock and no grant.
- A final reset, which must release the lock.

// File: rtl/scan_auth_gate.sv
module scan_auth_gate #(
  parameter int KEY_W = 32,
  parameter logic [KEY_W-1:0] KEY = 32'hA5C3_1E7B,
  parameter int MAX_TRIES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic key_bit_i,
  input  logic end_test_i,
  output logic tck_o,
  output logic fail_o,
  output logic locked_o,
  output logic scan_en_o
);
  localparam int CW = (KEY_W > 1) ? $clog2(KEY_W) : 1;
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(KEY_W - 1);
  localparam logic [TW-1:0] LAST_TRY = TW'(MAX_TRIES - 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_CHECK, S_GRANT, S_LOCK} st_t;

  st_t             st;
  logic            ph;
  logic [CW-1:0]   cnt;
  logic [KEY_W-1:0] sr;
  logic [TW-1:0]   tries;
  logic            fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= 1'b0;
      cnt    <= '0;
      sr     <= '0;
      tries  <= '0;
      fail_q <= 1'b0;
    end else begin
      fail_q <= 1'b0;
      case (st)
        S_IDLE: begin
          ph  <= 1'b0;
          cnt <= '0;
          if (req_i) st <= S_SHIFT;
        end
        S_SHIFT: begin
          if (!req_i) begin
            st  <= S_IDLE;
            ph  <= 1'b0;
            cnt <= '0;
          end else begin
            ph <= ~ph;
            if (ph) begin
              sr  <= {sr[KEY_W-2:0], key_bit_i};
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) st <= S_CHECK;
            end
          end
        end
        S_CHECK: begin
          if (sr == KEY) begin
            st <= S_GRANT;
          end else begin
            fail_q <= 1'b1;
            tries  <= tries + 1'b1;
            st     <= (tries == LAST_TRY) ? S_LOCK : S_IDLE;
          end
        end
        S_GRANT: if (end_test_i) st <= S_IDLE;
        S_LOCK:  st <= S_LOCK;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tck_o     = ph;
  assign fail_o    = fail_q;
  assign locked_o  = (st == S_LOCK);
  assign scan_en_o = (st == S_GRANT);
endmodule

// File: rtl/scan_auth_gate_chk.sv
module scan_auth_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic end_test_i,
  input logic tck_o,
  input logic fail_o,
  input logic locked_o,
  input logic scan_en_o
);
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en_o && !end_test_i |=> scan_en_o); // R4
  AST_FAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !fail_o); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o); // R6
  AST_LOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> !tck_o && !fail_o && !scan_en_o); // R7
  AST_NO_GRANT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_en_o && locked_o)); // R7
  AST_NO_TCK_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    !(tck_o && scan_en_o)); // R8
endmodule

bind scan_auth_gate scan_auth_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .end_test_i(end_test_i), .tck_o(tck_o),
  .fail_o(fail_o), .locked_o(locked_o), .scan_en_o(scan_en_o)
);

// File: tb/tb_scan_auth_gate.sv
module tb_scan_auth_gate;
  localparam logic [31:0] GOOD = 32'hA5C3_1E7B;
  localparam logic [32:0] VEC [4] = '{
    {1'b1, GOOD},
    {1'b0, GOOD ^ 32'h0000_0001},
    {1'b0, GOOD ^ 32'h8000_0000},
    {1'b1, GOOD}
  };

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, kbit = 1'b0, endt = 1'b0;
  logic tck, fail, locked, scan_en;
  int total = 0, bad = 0;

  scan_auth_gate dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .key_bit_i(kbit), .end_test_i(endt),
    .tck_o(tck), .fail_o(fail), .locked_o(locked), .scan_en_o(scan_en)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req_tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {tck,fail,locked,scan_en} actual=%b expected=%b", req_tag, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {tck, fail, locked, scan_en};
  endfunction

  task automatic send_key(input logic [31:0] k, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      kbit = k[31-i];
      do @(negedge clk); while (!tck);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run hung");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", outs(), 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", outs(), 4'b0000);
    repeat (3) @(negedge clk);
    chk("R8 idle tck low", outs(), 4'b0000);

    foreach (VEC[v]) begin
      req = 1'b1;
      send_key(VEC[v][31:0], 32);
      chk("R3 no verdict before check", outs(), 4'b0000);
      @(negedge clk);
      if (VEC[v][32]) begin
        chk("R4 R2 grant on match", outs(), 4'b0001);
        repeat (4) @(negedge clk);
        chk("R4 R8 grant held, tck low", outs(), 4'b0001);
        endt = 1'b1; req = 1'b0;
        @(negedge clk);
        endt = 1'b0;
        chk("R4 end of test drops grant", outs(), 4'b0000);
      end else begin
        chk("R5 fail pulse on mismatch", outs(), 4'b0100);
        @(negedge clk);
        chk("R5 pulse is one cycle", {1'b0, outs()[2:0]}, 4'b0000);
        req = 1'b0;
        repeat (2) @(negedge clk);
      end
    end

    req = 1'b1;
    send_key(GOOD, 31);
    req = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (c == 1 || c == 5) chk("R3 partial key discarded", outs(), 4'b0000);
    end
    req = 1'b1;
    send_key(GOOD, 32);
    @(negedge clk);
    chk("R3 R5 restart from first bit", outs(), 4'b0001);
    endt = 1'b1; req = 1'b0;
    @(negedge clk);
    endt = 1'b0;

    for (int f = 3; f <= 4; f++) begin
      req = 1'b1;
      send_key(~GOOD, 32);
      @(negedge clk);
      if (f == 3) chk("R6 third failure not locked", outs(), 4'b0100);
      else        chk("R6 fourth failure locks", outs(), 4'b0110);
      req = 1'b0;
      repeat (2) @(negedge clk);
    end

    req = 1'b1;
    kbit = GOOD[31];
    begin
      int seen = 0;
      for (int c = 0; c < 100; c++) begin
        @(negedge clk);
        kbit = GOOD[31 - (c % 32)];
        if (tck || scan_en || fail) seen++;
      end
      chk("R7 locked ignores request", {3'b0, seen != 0}, 4'b0000);
    end
    chk("R6 lock held", outs(), 4'b0010);
    req = 1'b0;

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 R6 reset clears lock", outs(), 4'b0000);
    req = 1'b1;
    send_key(GOOD, 32);
    @(negedge clk);
    chk("R4 grant after reset", outs(), 4'b0001);
    req = 1'b0;

    finish_run();
  end
endmodule